// File: doc/BRIEF.md
# Clock-Follower Serial Result Port with Cascade Input

This block hands a pair of 16-bit conversion results to a host that owns the serial clock. When the converter has a new result, the block loads both channel words into one 32-bit shift register in a chosen order. The host then selects the port by pulling chip-select and read low and clocks the word out, most significant bit first. All port pins are oversampled by the system clock through synchronisers, so the whole block runs in one clock domain. Edges of the host clock are recovered as single-cycle events.

Several converters can share one data line. Each port captures a cascade input on the clock edge that is not used for driving data, and feeds it into the tail of its shift register. The upstream device's bits therefore follow the local word on the line. When the read-previous mode is selected, the cascade input is ignored and zeros are shifted in instead. A result that arrives while a read is only partly done replaces the unread data, and the block reports this with a one-cycle error pulse in the system clock domain.

Top module: `daisy_serial_port`

## Requirements
- R1: Each active host-clock edge during a selected read puts the next bit of the 32-bit word on `sdout`, MSB first. The first active edge of a read presents bit 31.
- R2: With `sclk_inv` = 0, the rising edge of `sclk` is the active edge and the falling edge is the capture edge. With `sclk_inv` = 1, these two roles are swapped.
- R3: With `b_first` = 0, bits 31..16 of the word hold `res_a` and bits 15..0 hold `res_b`. With `b_first` = 1, the two halves are swapped.
- R4: On each capture edge after the first active edge, the level of `chain_in` enters the tail of the shift register. The value captured at capture edge k appears on `sdout` at active edge k+32, so the upstream MSB follows the local LSB.
- R5: With `prev_mode` = 1, `chain_in` is ignored, and bits 33 onward of a read are 0.
- R6: A `res_valid` pulse that arrives after at least one active edge of a read but before its 32nd active edge drives `rd_err` high for exactly one system clock. In every other case, `rd_err` stays 0.
- R7: A `res_valid` pulse always reloads the word and restarts the read, so the next read returns the new word from bit 31.
- R8: Host-clock edges while `cs_n` or `rd_n` is high do not advance the read. While the port is not selected, `sdout` is 0.
- R9: The host clock may idle either high or low. A capture edge that comes before the first active edge of a read is ignored.
- R10: After reset, `sdout` and `rd_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples every port pin |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Host-supplied serial clock |
| cs_n | input | 1 | Chip-select, active low |
| rd_n | input | 1 | Read enable, active low |
| sclk_inv | input | 1 | Swaps the active and capture edges of `sclk` |
| chain_in | input | 1 | Cascade data from the upstream device |
| prev_mode | input | 1 | Read-previous mode; disables the cascade input |
| res_a | input | 16 | Channel A result |
| res_b | input | 16 | Channel B result |
| res_valid | input | 1 | One-cycle strobe: a new result pair is ready |
| b_first | input | 1 | Channel order: 0 sends A first, 1 sends B first |
| sdout | output | 1 | Serial data output |
| rd_err | output | 1 | One-cycle pulse when an unfinished read is overwritten |

## Verification
A bit counter that drifts by one shows up at once: the word comes out shifted, and the cascade bits land one position early or late in a 64-bit read. A wrong edge role from the clock-invert pin garbles the very first bit, so a single read exposes it. A counter that misjudges whether a read is open either leaks a `rd_err` pulse after a complete read or misses one after a partial read. This is visible in the cycle after the strobe. A shift-register reload that is lost or misordered is seen on the first bit of the following read.

// File: rtl/dsport_pkg.sv
package dsport_pkg;
  typedef enum logic {
    ORD_A_FIRST = 1'b0,
    ORD_B_FIRST = 1'b1
  } order_e;
endpackage

// File: rtl/dsport_sync.sv
module dsport_sync #(
  parameter int unsigned     W       = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar i = 0; i < int'(STAGES); i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= RST_VAL;
          else        stage_q[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= RST_VAL;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dsport_edge.sv
module dsport_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic gate,
  output logic act_edge,
  output logic cap_edge
);
  logic lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl;
  end

  assign act_edge = gate &  lvl & ~lvl_d;
  assign cap_edge = gate & ~lvl &  lvl_d;

  AST_ACT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    act_edge |=> !act_edge); // R1
  AST_CAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_edge |=> !cap_edge); // R2
endmodule

// File: rtl/dsport_shift.sv
module dsport_shift
  import dsport_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_edge,
  input  logic              cap_edge,
  input  logic              chain_bit,
  input  logic              chain_en,
  input  logic              load,
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  input  order_e            order,
  output logic              sdo,
  output logic              err_pulse
);
  localparam int unsigned TOT   = 2 * WORD_W;
  localparam int unsigned CNT_W = $clog2(TOT + 1);

  function automatic logic [TOT-1:0] pack_pair(input logic [WORD_W-1:0] a,
                                               input logic [WORD_W-1:0] b,
                                               input order_e ord);
    return (ord == ORD_B_FIRST) ? {b, a} : {a, b};
  endfunction

  function automatic logic read_open(input logic [CNT_W-1:0] c);
    return (c != '0) && (c < CNT_W'(TOT));
  endfunction

  logic [TOT-1:0]   shreg;
  logic [CNT_W-1:0] cnt;
  logic             started;
  logic             shift_now;
  logic             tail_bit;

  assign started   = (cnt != '0);
  assign shift_now = cap_edge & started & ~load;
  assign tail_bit  = chain_en & chain_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      cnt       <= '0;
      sdo       <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      err_pulse <= load & read_open(cnt);
      if (load) begin
        shreg <= pack_pair(word_a, word_b, order);
        cnt   <= '0;
      end else begin
        if (act_edge) begin
          sdo <= shreg[TOT-1];
          if (cnt != CNT_W'(TOT)) cnt <= cnt + CNT_W'(1);
        end
        if (shift_now) shreg <= {shreg[TOT-2:0], tail_bit};
      end
    end
  end

  AST_ERR_PULSE:    assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse); // R6
  AST_ERR_CAUSE:    assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(load)); // R6
  AST_CNT_BOUND:    assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(TOT)); // R1
  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == '0)); // R7
  AST_CHAIN_OFF:    assert property (@(posedge clk) disable iff (!rst_n)
    (shift_now && !chain_en) |=> (shreg[0] == 1'b0)); // R5
  AST_EARLY_CAP:    assert property (@(posedge clk) disable iff (!rst_n)
    (cap_edge && !started && !load) |=> $stable(shreg)); // R9
endmodule

// File: rtl/daisy_serial_port.sv
module daisy_serial_port
  import dsport_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              sclk_inv,
  input  logic              chain_in,
  input  logic              prev_mode,
  input  logic [WORD_W-1:0] res_a,
  input  logic [WORD_W-1:0] res_b,
  input  logic              res_valid,
  input  logic              b_first,
  output logic              sdout,
  output logic              rd_err
);
  logic [1:0] sel_s;
  logic [1:0] dat_s;
  logic       gate;
  logic       eff_lvl;
  logic       act_edge;
  logic       cap_edge;
  logic       sdo;
  order_e     order;

  dsport_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync_sel (
    .clk(clk), .rst_n(rst_n), .d({cs_n, rd_n}), .q(sel_s));

  dsport_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .d({sclk, chain_in}), .q(dat_s));

  assign gate    = ~sel_s[1] & ~sel_s[0];
  assign eff_lvl = dat_s[1] ^ sclk_inv;
  assign order   = order_e'(b_first);

  dsport_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(eff_lvl), .gate(gate),
    .act_edge(act_edge), .cap_edge(cap_edge));

  dsport_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .act_edge(act_edge), .cap_edge(cap_edge),
    .chain_bit(dat_s[0]), .chain_en(~prev_mode), .load(res_valid),
    .word_a(res_a), .word_b(res_b), .order(order),
    .sdo(sdo), .err_pulse(rd_err));

  assign sdout = gate & sdo;

  AST_QUIET_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |-> !sdout); // R8
endmodule

// File: tb/daisy_serial_port_tb.sv
module daisy_serial_port_tb;
  localparam int CLK_P = 10;
  localparam int HALF  = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, cs_n = 1'b1, rd_n = 1'b1, sclk_inv = 1'b0;
  logic        chain_in = 1'b0, prev_mode = 1'b0, res_valid = 1'b0, b_first = 1'b0;
  logic [15:0] res_a = '0, res_b = '0;
  logic        sdout, rd_err;
  logic        e_lvl = 1'b0;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  daisy_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .rd_n(rd_n),
    .sclk_inv(sclk_inv), .chain_in(chain_in), .prev_mode(prev_mode),
    .res_a(res_a), .res_b(res_b), .res_valid(res_valid), .b_first(b_first),
    .sdout(sdout), .rd_err(rd_err));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_lvl(input logic v);
    e_lvl = v;
    sclk  = v ^ sclk_inv;
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] b, input logic exp_err, input string req);
    @(negedge clk);
    res_a = a; res_b = b; res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
    chk(req, {63'd0, rd_err}, {63'd0, exp_err});
    @(negedge clk);
    chk(req, {63'd0, rd_err}, 64'd0);
  endtask

  task automatic read_bits(input int n, input logic [63:0] pat, output logic [63:0] got);
    got = '0;
    cs_n = 1'b0; rd_n = 1'b0;
    waitn(4);
    for (int i = 0; i < n; i++) begin
      if (e_lvl) begin set_lvl(1'b0); waitn(HALF); end
      set_lvl(1'b1);
      chain_in = pat[63-i];
      waitn(HALF);
      got[63-i] = sdout;
      set_lvl(1'b0);
      waitn(HALF);
    end
  endtask

  task automatic end_read(input logic idle_hi);
    if (idle_hi) begin set_lvl(1'b1); waitn(HALF); end
    cs_n = 1'b1; rd_n = 1'b1;
    waitn(4);
  endtask

  task automatic t_reset();
    chk("R10 sdout", {63'd0, sdout}, 64'd0);
    chk("R10 rd_err", {63'd0, rd_err}, 64'd0);
  endtask

  task automatic t_order_a();
    logic [63:0] g;
    b_first = 1'b0;
    load(16'hA5C3, 16'h1E69, 1'b0, "R6 fresh load");
    read_bits(32, '0, g);
    end_read(1'b0);
    chk("R1 R3 A first", g[63:32], {32'd0, 16'hA5C3, 16'h1E69});
  endtask

  task automatic t_order_b();
    logic [63:0] g;
    b_first = 1'b1;
    load(16'h8001, 16'h7FFE, 1'b0, "R6 load after full read");
    read_bits(32, '0, g);
    end_read(1'b0);
    b_first = 1'b0;
    chk("R3 B first", g[63:32], {32'd0, 16'h7FFE, 16'h8001});
  endtask

  task automatic t_inverted();
    logic [63:0] g;
    sclk_inv = 1'b1;
    set_lvl(1'b0);
    waitn(4);
    load(16'h3C0F, 16'hF0C3, 1'b0, "R6 load");
    read_bits(32, '0, g);
    end_read(1'b0);
    sclk_inv = 1'b0;
    set_lvl(1'b0);
    waitn(4);
    chk("R2 inverted edges", g[63:32], {32'd0, 16'h3C0F, 16'hF0C3});
  endtask

  task automatic t_chain();
    logic [63:0] g;
    logic [63:0] pat = 64'hC3A5_0FF1_DEAD_BEEF;
    load(16'h1234, 16'h5678, 1'b0, "R6 load");
    read_bits(64, pat, g);
    end_read(1'b0);
    chk("R4 local word", g[63:32], {32'd0, 16'h1234, 16'h5678});
    chk("R4 cascade after 32", {32'd0, g[31:0]}, {32'd0, pat[63:32]});
    chk("R4 upstream MSB follows LSB", {63'd0, g[31]}, {63'd0, pat[63]});
  endtask

  task automatic t_prev_mode();
    logic [63:0] g;
    prev_mode = 1'b1;
    load(16'hFFFF, 16'hFFFF, 1'b0, "R6 load");
    read_bits(64, '1, g);
    end_read(1'b0);
    prev_mode = 1'b0;
    chk("R5 cascade ignored", {32'd0, g[31:0]}, 64'd0);
    chk("R5 local word", g[63:32], {32'd0, 32'hFFFF_FFFF});
  endtask

  task automatic t_partial();
    logic [63:0] g;
    load(16'hAAAA, 16'h5555, 1'b0, "R6 load");
    read_bits(10, '0, g);
    end_read(1'b0);
    chk("R1 partial bits", {54'd0, g[63:54]}, {54'd0, 10'b1010101010});
    load(16'h0F0F, 16'h9696, 1'b1, "R6 overwrite mid read");
    read_bits(32, '0, g);
    end_read(1'b0);
    chk("R7 new word after reload", g[63:32], {32'd0, 16'h0F0F, 16'h9696});
    load(16'h1111, 16'h2222, 1'b0, "R6 after complete read");
    load(16'h3333, 16'h4444, 1'b0, "R6 no read started");
  endtask

  task automatic t_gate();
    logic [63:0] g;
    load(16'hC001, 16'h0ACE, 1'b0, "R6 load");
    cs_n = 1'b0; rd_n = 1'b1;
    waitn(4);
    for (int i = 0; i < 3; i++) begin
      set_lvl(1'b1); waitn(HALF); set_lvl(1'b0); waitn(HALF);
    end
    chk("R8 sdout low unselected", {63'd0, sdout}, 64'd0);
    cs_n = 1'b1;
    waitn(4);
    read_bits(32, '0, g);
    end_read(1'b0);
    chk("R8 clocks ignored", g[63:32], {32'd0, 16'hC001, 16'h0ACE});
    waitn(4);
    chk("R8 sdout low after read", {63'd0, sdout}, 64'd0);
  endtask

  task automatic t_idle_high();
    logic [63:0] g;
    set_lvl(1'b1);
    waitn(4);
    load(16'h8421, 16'h1248, 1'b0, "R6 load");
    read_bits(32, '0, g);
    end_read(1'b1);
    chk("R9 idle high clock", g[63:32], {32'd0, 16'h8421, 16'h1248});
    set_lvl(1'b0);
    waitn(4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    waitn(3);
    chk("R10 sdout in reset", {63'd0, sdout}, 64'd0);
    rst_n = 1'b1;
    waitn(4);
    t_reset();
    t_order_a();
    t_order_b();
    t_inverted();
    t_chain();
    t_prev_mode();
    t_partial();
    t_gate();
    t_idle_high();
    finish_run();
  end

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule